// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Polarity and Pair Joining

This block produces six pulse-width modulated outputs. Each channel runs an 8-bit up-counter that restarts after a programmable period. The output changes level when the counter passes a programmable duty count. A per-channel polarity bit selects the level the output takes at the start of each period. A per-channel enable bit starts the channel at the following clock edge, and the counter starts from zero. Period and duty values written by software are copied into working registers only at the start of a period, so a running waveform never sees a half-updated setting.

Channels are grouped in pairs (0/1, 2/3, 4/5). When a pair is joined, its two 8-bit counters form one 16-bit counter. The even channel supplies the high byte of the counter, period and duty, and the odd channel supplies the low byte. The joined waveform appears on the odd output, using the odd channel's enable and polarity. The even channel's enable is ignored and its output stays low. Software reaches all settings through a simple register port with a write strobe and a combinational read path.

Top module: `pwmMulti`

## Requirements
- R1: After reset every output is low, and the enable, polarity and join registers all read 0.
- R2: Register map by `regSel`: 0 = enable (bit c is channel c), 1 = polarity (bit c is channel c), 2 = join (bit p joins pair 2p/2p+1), 8+c = period of channel c, 16+c = duty of channel c. Every register can be written and read back at any time. Bits 6 and 7 of the enable and polarity registers read as 0 and have no effect. Addresses outside the map read 0.
- R3: A channel whose enable is written to 1 keeps its output low in the cycle after the write edge. Its waveform starts one edge later, with the counter at 0.
- R4: With polarity 1, an enabled channel's output is high while its counter is below the duty count and low from there to the end of the period. The counter runs from 0 up to period-1 and then restarts. A period value of 0 gives 256 counts.
- R5: With polarity 0, the output is low while the counter is below the duty count and high for the rest of the period.
- R6: A duty count of 0 keeps the output at the level opposite to its start level for the whole period. A duty count equal to or above the period keeps it at the start level for the whole period.
- R7: A polarity write has effect at once: the output reflects the new polarity in the cycle after the write edge, even in the middle of a period.
- R8: Period and duty writes to a running channel take effect only when its counter next restarts.
- R9: Clearing a channel's enable drives its output low in the cycle after the write edge. Enabling it again restarts its counter from 0.
- R10: While a pair is joined, the even channel's output stays low and its enable has no effect. The odd output carries a 16-bit waveform whose counter, period and duty are {even byte, odd byte}, following the odd channel's enable and polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 5 | Register address for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register (combinational) |
| pwmOut | output | 6 | Modulated outputs, bit c for channel c |

## Verification
The bench targets the first cycle after an enable write. A design that starts at once shows the start level one cycle early. It rewrites the duty count in the middle of a period, where a design without working copies bends the running pulse before the counter restarts. It flips polarity on a channel whose duty exceeds its period, so a design that buffers the bit leaves the output unchanged for a whole period. For a joined pair it sets only the even enable and uses a 16-bit period of 260. A design that listens to the even enable, leaks the even output or ignores the high byte shows the wrong output or the wrong period.

// File: rtl/pwmPkg.sv
package pwmPkg;
  parameter int NUM_CH = 6;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 5;
  localparam int NUM_PAIR = NUM_CH / 2;
  localparam int JOIN_W = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] SEL_EN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SEL_POL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SEL_JOIN = ADDR_W'(2);
  localparam int SEL_PER_BASE  = 8;
  localparam int SEL_DUTY_BASE = 16;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_CH-1:0]   start;    // begin a fresh period at the next edge
    logic [NUM_CH-1:0]   run;      // channel is producing its waveform
    logic [NUM_CH-1:0]   pol;      // start level per channel
    logic [NUM_PAIR-1:0] joinPair; // pair works as one wide channel
  } ctlStrobe_t;
endpackage

// File: rtl/pwmCtrl.sv
module pwmCtrl
  import pwmPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        regSel,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_CH*DATA_W-1:0] perFlat,
  output logic [NUM_CH*DATA_W-1:0] dutyFlat,
  output ctlStrobe_t               ctl
);
  logic [NUM_CH-1:0]   enReg, polReg, runQ, chEn, evenMask;
  logic [NUM_PAIR-1:0] joinReg;
  logic [DATA_W-1:0]   perReg  [NUM_CH];
  logic [DATA_W-1:0]   dutyReg [NUM_CH];
  logic                joinChange;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : gMask
    assign evenMask[2*p]   = joinReg[p];
    assign evenMask[2*p+1] = 1'b0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gFlat
    assign perFlat[c*DATA_W +: DATA_W]  = perReg[c];
    assign dutyFlat[c*DATA_W +: DATA_W] = dutyReg[c];
  end

  assign chEn       = enReg & ~evenMask;
  assign joinChange = wrEn && (regSel == SEL_JOIN) && (wrData[NUM_PAIR-1:0] != joinReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      polReg  <= '0;
      joinReg <= '0;
      runQ    <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        perReg[c]  <= '0;
        dutyReg[c] <= '0;
      end
    end else begin
      runQ <= joinChange ? '0 : chEn;
      if (wrEn) begin
        if (regSel == SEL_EN)   enReg   <= wrData[NUM_CH-1:0];
        if (regSel == SEL_POL)  polReg  <= wrData[NUM_CH-1:0];
        if (regSel == SEL_JOIN) joinReg <= wrData[NUM_PAIR-1:0];
        for (int c = 0; c < NUM_CH; c++) begin
          if (regSel == ADDR_W'(SEL_PER_BASE + c))  perReg[c]  <= wrData;
          if (regSel == ADDR_W'(SEL_DUTY_BASE + c)) dutyReg[c] <= wrData;
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (regSel == SEL_EN)   rdData[NUM_CH-1:0]   = enReg;
    if (regSel == SEL_POL)  rdData[NUM_CH-1:0]   = polReg;
    if (regSel == SEL_JOIN) rdData[NUM_PAIR-1:0] = joinReg;
    for (int c = 0; c < NUM_CH; c++) begin
      if (regSel == ADDR_W'(SEL_PER_BASE + c))  rdData = perReg[c];
      if (regSel == ADDR_W'(SEL_DUTY_BASE + c)) rdData = dutyReg[c];
    end
  end

  assign ctl.start    = chEn & ~runQ;
  assign ctl.run      = chEn & runQ;
  assign ctl.pol      = polReg;
  assign ctl.joinPair = joinReg;
endmodule

// File: rtl/pwmDatapath.sv
module pwmDatapath
  import pwmPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               ctl,
  input  logic [NUM_CH*DATA_W-1:0] perFlat,
  input  logic [NUM_CH*DATA_W-1:0] dutyFlat,
  output logic [NUM_CH-1:0]        pwmOut
);
  for (genvar p = 0; p < NUM_PAIR; p++) begin : gPair
    localparam int EV = 2 * p;
    localparam int OD = 2 * p + 1;

    logic [DATA_W-1:0] cntE, cntO, perE, perO, dutyE, dutyO;
    logic [DATA_W-1:0] perEIn, perOIn, dutyEIn, dutyOIn;
    logic [JOIN_W-1:0] cntJ, perJ, dutyJ;
    logic              wrapE, wrapO, wrapJ, ltE, ltO, ltJ, joined;

    assign perEIn  = perFlat[EV*DATA_W +: DATA_W];
    assign perOIn  = perFlat[OD*DATA_W +: DATA_W];
    assign dutyEIn = dutyFlat[EV*DATA_W +: DATA_W];
    assign dutyOIn = dutyFlat[OD*DATA_W +: DATA_W];

    assign joined = ctl.joinPair[p];
    assign cntJ   = {cntE, cntO};
    assign perJ   = {perE, perO};
    assign dutyJ  = {dutyE, dutyO};

    // a period of zero wraps at the full count
    assign wrapE = (cntE == perE - 1'b1);
    assign wrapO = (cntO == perO - 1'b1);
    assign wrapJ = (cntJ == perJ - 1'b1);
    assign ltE   = (cntE < dutyE);
    assign ltO   = (cntO < dutyO);
    assign ltJ   = (cntJ < dutyJ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntE <= '0; cntO <= '0;
        perE <= '0; perO <= '0; dutyE <= '0; dutyO <= '0;
      end else if (joined) begin
        if (ctl.start[OD] || (ctl.run[OD] && wrapJ)) begin
          cntE  <= '0;      cntO  <= '0;
          perE  <= perEIn;  perO  <= perOIn;
          dutyE <= dutyEIn; dutyO <= dutyOIn;
        end else if (!ctl.run[OD]) begin
          cntE <= '0; cntO <= '0;
        end else begin
          {cntE, cntO} <= cntJ + 1'b1;
        end
      end else begin
        if (ctl.start[EV] || (ctl.run[EV] && wrapE)) begin
          cntE <= '0; perE <= perEIn; dutyE <= dutyEIn;
        end else if (!ctl.run[EV]) begin
          cntE <= '0;
        end else begin
          cntE <= cntE + 1'b1;
        end
        if (ctl.start[OD] || (ctl.run[OD] && wrapO)) begin
          cntO <= '0; perO <= perOIn; dutyO <= dutyOIn;
        end else if (!ctl.run[OD]) begin
          cntO <= '0;
        end else begin
          cntO <= cntO + 1'b1;
        end
      end
    end

    logic ltSel;
    assign ltSel      = joined ? ltJ : ltO;
    assign pwmOut[EV] = !joined && ctl.run[EV] && (ctl.pol[EV] ? ltE : !ltE);
    assign pwmOut[OD] = ctl.run[OD] && (ctl.pol[OD] ? ltSel : !ltSel);
  end
endmodule

// File: rtl/pwmMulti.sv
module pwmMulti
  import pwmPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  ctlStrobe_t               ctl;
  logic [NUM_CH*DATA_W-1:0] perFlat, dutyFlat;

  pwmCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .regSel   (regSel),
    .wrData   (wrData),
    .rdData   (rdData),
    .perFlat  (perFlat),
    .dutyFlat (dutyFlat),
    .ctl      (ctl)
  );

  pwmDatapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .perFlat  (perFlat),
    .dutyFlat (dutyFlat),
    .pwmOut   (pwmOut)
  );
endmodule

// File: rtl/pwmChecker.sv
module pwmChecker
  import pwmPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regSel,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [NUM_CH-1:0] pwmOut
);
  logic [NUM_CH-1:0]   enSeen, evenJoined;
  logic [NUM_PAIR-1:0] joinSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSeen   <= '0;
      joinSeen <= '0;
    end else if (wrEn) begin
      if (regSel == SEL_EN)   enSeen   <= wrData[NUM_CH-1:0];
      if (regSel == SEL_JOIN) joinSeen <= wrData[NUM_PAIR-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : gEven
    assign evenJoined[2*p]   = joinSeen[p];
    assign evenJoined[2*p+1] = 1'b0;
  end

  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_EN) |=> ((pwmOut & ~$past(wrData[NUM_CH-1:0])) == '0)); // R9

  AST_ENABLE_DEFERRED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_EN) |=>
      ((pwmOut & $past(wrData[NUM_CH-1:0]) & ~$past(enSeen)) == '0)); // R3

  AST_JOINED_EVEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ((pwmOut & evenJoined) == '0)); // R10

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_EN || regSel == SEL_POL) |-> ((rdData >> NUM_CH) == '0)); // R2
endmodule

bind pwmMulti pwmChecker uChk (.*);

// File: tb/sim_pwmMulti.sv
`timescale 1ns/1ps
module sim_pwmMulti;
  import pwmPkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] regSel = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [NUM_CH-1:0] pwmOut;

  always #2 clk = ~clk;

  pwmMulti u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  int checks = 0;
  int errors = 0;
  logic [NUM_CH-1:0] qMask[$];
  logic [NUM_CH-1:0] qVal[$];
  string             qTag[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per falling edge
  always @(negedge clk) begin
    if (qVal.size() > 0) begin
      logic [NUM_CH-1:0] m, v;
      string t;
      m = qMask.pop_front();
      v = qVal.pop_front();
      t = qTag.pop_front();
      check(t, 32'(pwmOut & m), 32'(v & m));
    end
  end

  task automatic expectOut(input logic [NUM_CH-1:0] m, input logic [NUM_CH-1:0] v, input string tag);
    qMask.push_back(m);
    qVal.push_back(v);
    qTag.push_back(tag);
  endtask

  task automatic drain;
    wait (qVal.size() == 0);
  endtask

  task automatic busWrite(input int a, input logic [DATA_W-1:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; regSel = ADDR_W'(a); wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic busRead(input int a, input logic [DATA_W-1:0] exp, input string tag);
    @(posedge clk); #1;
    regSel = ADDR_W'(a);
    #1;
    check(tag, 32'(rdData), 32'(exp));
  endtask

  // expected waveform after an enable write, derived from the requirements
  task automatic expectWave(input int ch, input int per, input int duty, input bit pol,
                            input int n, input logic [NUM_CH-1:0] zeroMask, input string tag);
    logic [NUM_CH-1:0] m;
    m = zeroMask;
    m[ch] = 1'b1;
    expectOut(m, '0, "R3 output held one cycle after enable");
    for (int k = 0; k < n; k++) begin
      int cnt;
      bit lt;
      logic [NUM_CH-1:0] v;
      cnt = k % per;
      lt = (cnt < duty);
      v = '0;
      v[ch] = pol ? lt : !lt;
      expectOut(m, v, tag);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 outputs after reset", 32'(pwmOut), 32'h0);
    busRead(SEL_EN,   8'h00, "R1 enable reset");
    busRead(SEL_POL,  8'h00, "R1 polarity reset");
    busRead(SEL_JOIN, 8'h00, "R1 join reset");

    // R2 register access and reserved bits
    busWrite(SEL_POL, 8'hFF);
    busRead(SEL_POL, 8'h3F, "R2 polarity reserved bits");
    busWrite(SEL_POL, 8'h00);
    busWrite(SEL_EN, 8'hC0);
    busRead(SEL_EN, 8'h00, "R2 enable reserved bits");
    check("R2 reserved enable bits drive nothing", 32'(pwmOut), 32'h0);
    busWrite(SEL_PER_BASE + 3, 8'hA5);
    busRead(SEL_PER_BASE + 3, 8'hA5, "R2 period readback");
    busWrite(SEL_DUTY_BASE + 5, 8'h3C);
    busRead(SEL_DUTY_BASE + 5, 8'h3C, "R2 duty readback");
    busRead(30, 8'h00, "R2 unmapped address");

    // R3 / R4: channel 0, polarity 1, period 5, duty 2
    busWrite(SEL_PER_BASE + 0, 8'd5);
    busWrite(SEL_DUTY_BASE + 0, 8'd2);
    busWrite(SEL_POL, 8'h01);
    busWrite(SEL_EN, 8'h01);
    expectWave(0, 5, 2, 1'b1, 12, '0, "R4 high-first waveform");
    drain();

    // R9 disable at once, restart from zero
    busWrite(SEL_EN, 8'h00);
    expectOut(6'h01, 6'h00, "R9 output low after disable");
    expectOut(6'h01, 6'h00, "R9 output stays low");
    drain();
    busWrite(SEL_EN, 8'h01);
    expectWave(0, 5, 2, 1'b1, 8, '0, "R9 restart from count zero");
    drain();
    busWrite(SEL_EN, 8'h00);

    // R5: channel 1, polarity 0, period 6, duty 4
    busWrite(SEL_PER_BASE + 1, 8'd6);
    busWrite(SEL_DUTY_BASE + 1, 8'd4);
    busWrite(SEL_POL, 8'h00);
    busWrite(SEL_EN, 8'h02);
    expectWave(1, 6, 4, 1'b0, 14, '0, "R5 low-first waveform");
    drain();
    busWrite(SEL_EN, 8'h00);

    // R6 duty extremes
    busWrite(SEL_PER_BASE + 2, 8'd7);
    busWrite(SEL_DUTY_BASE + 2, 8'd0);
    busWrite(SEL_PER_BASE + 3, 8'd7);
    busWrite(SEL_DUTY_BASE + 3, 8'd9);
    busWrite(SEL_POL, 8'h0C);
    busWrite(SEL_EN, 8'h04);
    expectWave(2, 7, 0, 1'b1, 10, '0, "R6 duty zero stays inactive");
    drain();
    busWrite(SEL_EN, 8'h0C);
    expectWave(3, 7, 9, 1'b1, 10, '0, "R6 duty above period stays active");
    drain();

    // R7 polarity acts at once
    busWrite(SEL_POL, 8'h04);
    for (int i = 0; i < 3; i++) expectOut(6'h08, 6'h00, "R7 polarity cleared mid-period");
    drain();
    busWrite(SEL_POL, 8'h0C);
    for (int i = 0; i < 3; i++) expectOut(6'h08, 6'h08, "R7 polarity set mid-period");
    drain();
    busWrite(SEL_EN, 8'h00);

    // R8 duty change waits for the counter restart
    busWrite(SEL_PER_BASE + 4, 8'd4);
    busWrite(SEL_DUTY_BASE + 4, 8'd1);
    busWrite(SEL_POL, 8'h10);
    busWrite(SEL_EN, 8'h10);
    begin
      bit seq [11] = '{0, 1, 0, 0, 0, 1, 1, 1, 0, 1, 1};
      for (int i = 0; i < 11; i++)
        expectOut(6'h10, seq[i] ? 6'h10 : 6'h00, "R8 duty applied at restart");
    end
    busWrite(SEL_DUTY_BASE + 4, 8'd3);
    drain();
    busWrite(SEL_EN, 8'h00);

    // R10 joined pair 0: period 0x0104, duty 0x0082
    busWrite(SEL_JOIN, 8'h01);
    busRead(SEL_JOIN, 8'h01, "R2 join readback");
    busWrite(SEL_PER_BASE + 0, 8'h01);
    busWrite(SEL_PER_BASE + 1, 8'h04);
    busWrite(SEL_DUTY_BASE + 0, 8'h00);
    busWrite(SEL_DUTY_BASE + 1, 8'h82);
    busWrite(SEL_POL, 8'h03);
    busWrite(SEL_EN, 8'h01);
    for (int i = 0; i < 5; i++) expectOut(6'h03, 6'h00, "R10 even enable ignored");
    drain();
    busWrite(SEL_EN, 8'h03);
    expectWave(1, 260, 130, 1'b1, 280, 6'h01, "R10 joined 16-bit waveform");
    drain();
    busWrite(SEL_EN, 8'h00);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule